// File: doc/BRIEF.md
# Receive Descriptor Writeback and Frame Classifier

This block takes each incoming frame and settles what becomes of it on the receive side of an Ethernet controller. When a frame starts, it gets the first six destination bytes and the frame length. It sorts the destination into unicast, multicast or broadcast. It then reads the descriptor at the current receive pointer from a word-wide memory port. If software owns nothing there, the frame is discarded with an abnormal event. Otherwise the block writes a length/status word back into the descriptor and moves the pointer along the ring.

The block also keeps four 64-bit receive statistics: bytes, frames, multicast frames and broadcast frames. It reports the buffer 1 address of the claimed descriptor so that a separate payload mover can fill it. Descriptors are 32 bytes apart. Each descriptor has three words:

- Byte offset 0: the ownership/status word.
- Byte offset 4: the buffer sizes.
- Byte offset 8: the buffer 1 address.

The memory returns read data one cycle after the request.

Top module: `rx_desc_writeback`

## Requirements
- R1: While `rx_en` is 0, a frame start is refused: no memory access, no event, and the pointer and counters keep their values.
- R2: A frame whose length is below 12 bytes makes no memory access and changes no counter. It still pulses `ev_rx_done` and `ev_nis` for one cycle, in the cycle after the start.
- R3: If bit 31 of the descriptor word at byte offset 0 is 0, the frame is discarded. `ev_buf_unavail` and `ev_ais` pulse together three cycles after the start, nothing is written, and the pointer and counters are kept.
- R4: On acceptance, the word at byte offset 0 of the current descriptor is overwritten with (length + 4) in bits 31:16 and 0x0300 in bits 15:0.
- R5: If bit 15 of the word at byte offset 4 is set, the pointer reloads from `ring_base` after the writeback. Otherwise it advances by 32.
- R6: The destination is broadcast when all 48 bits are 1. It is unicast when bit 0 of the first byte (`frm_dst[0]`) is 0, and multicast in all other cases.
- R7: Each accepted frame adds length + 4 to `cnt_bytes` and 1 to `cnt_frames`. It also adds 1 to `cnt_mcast` or `cnt_bcast` when the frame is of that class.
- R8: Each accepted frame pulses `ev_rx_done`, `ev_nis` and `buf1_valid` five cycles after the start. At that point `buf1_addr` holds the word at byte offset 8 and the new pointer and counters are visible.
- R9: Reset clears all four 64-bit counters, the pointer and every event output. The counters wrap silently.
- R10: A pulse on `base_wr` copies `ring_base` into the current receive pointer.
- R11: A frame start that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Base address of the descriptor ring |
| base_wr | input | 1 | Load the pointer from `ring_base` |
| frm_start | input | 1 | One-cycle frame start |
| frm_dst | input | 48 | Destination bytes, first byte in bits 7:0 |
| frm_len | input | 16 | Frame length in bytes, without CRC |
| busy | output | 1 | A frame is in progress |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_wr_en | output | 1 | Descriptor write request |
| mem_addr | output | 32 | Byte address for read or write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd_en` |
| cur_ptr | output | 32 | Current receive descriptor pointer |
| buf1_addr | output | 32 | Buffer 1 address of the last claimed descriptor |
| buf1_valid | output | 1 | `buf1_addr` updated (frame accepted) |
| ev_rx_done | output | 1 | Receive-done event pulse |
| ev_nis | output | 1 | Normal-summary event pulse |
| ev_buf_unavail | output | 1 | Buffer-unavailable event pulse |
| ev_ais | output | 1 | Abnormal-summary event pulse |
| cnt_bytes | output | 64 | Received byte count |
| cnt_frames | output | 64 | Received frame count |
| cnt_mcast | output | 64 | Multicast frame count |
| cnt_bcast | output | 64 | Broadcast frame count |

## Verification
Each outcome has a fixed latency, counted from the clock edge that samples `frm_start`:

- A runt's events appear one cycle later.
- A missing-descriptor event appears three cycles later, after the status word has returned.
- An accepted frame's events, pointer, buffer address and counters appear five cycles later. This is after three reads and one write cycle.

The driver records the cycle of each start and queues the outcome it expects, with the due cycle. The monitor compares each event against the queue entry in exactly that cycle, and it compares every memory write against a separate queue of expected writes. Any event or write that nothing predicted is reported as a failure.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    localparam int unsigned LEN_W        = 16;
    localparam int unsigned DST_W        = 48;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned MIN_FRAME    = 12;
    localparam int unsigned CRC_BYTES    = 4;
    localparam int unsigned OWN_BIT      = 31;
    localparam int unsigned RING_END_BIT = 15;
    localparam int unsigned SIZE_OFS     = 4;
    localparam int unsigned BUFA_OFS     = 8;
    localparam logic [15:0] STAT_FLAGS   = 16'h0300;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_SIZE,
        ST_FETCH_BUF,
        ST_WRITEBACK
    } rx_state_t;

    typedef enum logic [1:0] {
        CLS_UNI,
        CLS_MULTI,
        CLS_BCAST
    } dst_class_t;

    typedef struct packed {
        logic rx_done;
        logic nis;
        logic buf_unavail;
        logic ais;
    } rx_events_t;

    function automatic dst_class_t classify(input logic [DST_W-1:0] dst);
        if (&dst)
            return CLS_BCAST;
        else if (!dst[0])
            return CLS_UNI;
        else
            return CLS_MULTI;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] tot;
        tot = len + LEN_W'(CRC_BYTES);
        return {tot, STAT_FLAGS};
    endfunction

endpackage

// File: rtl/rxwb_classifier.sv
module rxwb_classifier
    import rxwb_pkg::*;
(
    input  logic [DST_W-1:0] dst,
    output dst_class_t       cls
);
    always_comb cls = classify(dst);
endmodule

// File: rtl/rxwb_seq.sv
module rxwb_seq
    import rxwb_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned DESC_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [AW-1:0]     ring_base,
    input  logic              base_wr,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  dst_class_t        cls_in,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic [AW-1:0]     cur_ptr,
    output logic [WORD_W-1:0] buf1_addr,
    output logic              buf1_valid,
    output rx_events_t        events,
    output logic              commit,
    output logic [LEN_W-1:0]  commit_len,
    output dst_class_t        commit_cls
);
    localparam logic [AW-1:0] STEP   = AW'(DESC_BYTES);
    localparam logic [AW-1:0] OFS_SZ = AW'(SIZE_OFS);
    localparam logic [AW-1:0] OFS_BA = AW'(BUFA_OFS);

    rx_state_t        state;
    logic [LEN_W-1:0] len_q;
    dst_class_t       cls_q;
    logic             wrap_q;

    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = status_word(len_q);
        unique case (state)
            ST_FETCH_CTL:  mem_rd_en = 1'b1;
            ST_FETCH_SIZE: begin
                mem_rd_en = mem_rdata[OWN_BIT];
                mem_addr  = cur_ptr + OFS_SZ;
            end
            ST_FETCH_BUF: begin
                mem_rd_en = 1'b1;
                mem_addr  = cur_ptr + OFS_BA;
            end
            ST_WRITEBACK:  mem_wr_en = 1'b1;
            default: ;
        endcase
    end

    assign busy       = (state != ST_IDLE);
    assign commit     = (state == ST_WRITEBACK);
    assign commit_len = len_q;
    assign commit_cls = cls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_ptr    <= '0;
            buf1_addr  <= '0;
            buf1_valid <= 1'b0;
            events     <= '0;
            len_q      <= '0;
            cls_q      <= CLS_UNI;
            wrap_q     <= 1'b0;
        end else begin
            events     <= '0;
            buf1_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (frm_start && rx_en) begin
                        if (frm_len < LEN_W'(MIN_FRAME)) begin
                            events.rx_done <= 1'b1;
                            events.nis     <= 1'b1;
                        end else begin
                            len_q <= frm_len;
                            cls_q <= cls_in;
                            state <= ST_FETCH_CTL;
                        end
                    end
                end
                ST_FETCH_CTL: state <= ST_FETCH_SIZE;
                ST_FETCH_SIZE: begin
                    if (!mem_rdata[OWN_BIT]) begin
                        events.buf_unavail <= 1'b1;
                        events.ais         <= 1'b1;
                        state              <= ST_IDLE;
                    end else begin
                        state <= ST_FETCH_BUF;
                    end
                end
                ST_FETCH_BUF: begin
                    wrap_q <= mem_rdata[RING_END_BIT];
                    state  <= ST_WRITEBACK;
                end
                ST_WRITEBACK: begin
                    buf1_addr      <= mem_rdata;
                    buf1_valid     <= 1'b1;
                    events.rx_done <= 1'b1;
                    events.nis     <= 1'b1;
                    cur_ptr        <= wrap_q ? ring_base : cur_ptr + STEP;
                    state          <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (base_wr)
                cur_ptr <= ring_base;
        end
    end
endmodule

// File: rtl/rxwb_stats.sv
module rxwb_stats
    import rxwb_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [LEN_W-1:0] len,
    input  dst_class_t       cls,
    output logic [CNT_W-1:0] cnt_bytes,
    output logic [CNT_W-1:0] cnt_frames,
    output logic [CNT_W-1:0] cnt_mcast,
    output logic [CNT_W-1:0] cnt_bcast
);
    localparam int unsigned NUM_CNT = 4;

    logic [NUM_CNT-1:0][CNT_W-1:0] inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    always_comb begin
        inc[0] = CNT_W'(len) + CNT_W'(CRC_BYTES);
        inc[1] = CNT_W'(1);
        inc[2] = CNT_W'(cls == CLS_MULTI);
        inc[3] = CNT_W'(cls == CLS_BCAST);
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[g] <= '0;
            else if (commit)
                cnt_q[g] <= cnt_q[g] + inc[g];
        end
    end

    assign cnt_bytes  = cnt_q[0];
    assign cnt_frames = cnt_q[1];
    assign cnt_mcast  = cnt_q[2];
    assign cnt_bcast  = cnt_q[3];
endmodule

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback
    import rxwb_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned DESC_BYTES = 32,
    parameter int unsigned CNT_W      = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [AW-1:0]     ring_base,
    input  logic              base_wr,
    input  logic              frm_start,
    input  logic [47:0]       frm_dst,
    input  logic [15:0]       frm_len,
    output logic              busy,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [AW-1:0]     cur_ptr,
    output logic [31:0]       buf1_addr,
    output logic              buf1_valid,
    output logic              ev_rx_done,
    output logic              ev_nis,
    output logic              ev_buf_unavail,
    output logic              ev_ais,
    output logic [CNT_W-1:0]  cnt_bytes,
    output logic [CNT_W-1:0]  cnt_frames,
    output logic [CNT_W-1:0]  cnt_mcast,
    output logic [CNT_W-1:0]  cnt_bcast
);
    dst_class_t       cls;
    rx_events_t       ev;
    logic             commit;
    logic [LEN_W-1:0] commit_len;
    dst_class_t       commit_cls;

    rxwb_classifier u_cls (
        .dst (frm_dst),
        .cls (cls)
    );

    rxwb_seq #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .ring_base  (ring_base),
        .base_wr    (base_wr),
        .frm_start  (frm_start),
        .frm_len    (frm_len),
        .cls_in     (cls),
        .mem_rdata  (mem_rdata),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .cur_ptr    (cur_ptr),
        .buf1_addr  (buf1_addr),
        .buf1_valid (buf1_valid),
        .events     (ev),
        .commit     (commit),
        .commit_len (commit_len),
        .commit_cls (commit_cls)
    );

    rxwb_stats #(.CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .len        (commit_len),
        .cls        (commit_cls),
        .cnt_bytes  (cnt_bytes),
        .cnt_frames (cnt_frames),
        .cnt_mcast  (cnt_mcast),
        .cnt_bcast  (cnt_bcast)
    );

    assign ev_rx_done     = ev.rx_done;
    assign ev_nis         = ev.nis;
    assign ev_buf_unavail = ev.buf_unavail;
    assign ev_ais         = ev.ais;
endmodule

// File: rtl/rxwb_checker.sv
module rxwb_checker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic [AW-1:0]    ring_base,
    input logic             base_wr,
    input logic             frm_start,
    input logic [15:0]      frm_len,
    input logic             busy,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic [31:0]      mem_wdata,
    input logic [AW-1:0]    cur_ptr,
    input logic             buf1_valid,
    input logic             ev_rx_done,
    input logic             ev_nis,
    input logic             ev_buf_unavail,
    input logic             ev_ais,
    input logic [CNT_W-1:0] cnt_frames,
    input logic [CNT_W-1:0] cnt_bytes
);
    p_refuse_r1: assert property (@(posedge clk) disable iff (rst)
        (frm_start && !rx_en && !busy && !base_wr) |=> ($stable(cur_ptr) && !mem_rd_en && !ev_rx_done));

    p_runt_r2: assert property (@(posedge clk) disable iff (rst)
        (frm_start && rx_en && !busy && frm_len < 16'd12) |=> (ev_rx_done && ev_nis && !mem_rd_en));

    p_nobuf_r3: assert property (@(posedge clk) disable iff (rst)
        ev_buf_unavail |-> (ev_ais && !ev_rx_done && !buf1_valid));

    p_status_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wdata[15:0] == 16'h0300 && mem_wdata[31:16] >= 16'd16));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (buf1_valid && !$past(base_wr)) |-> (cur_ptr == ring_base || cur_ptr == $past(cur_ptr) + AW'(32)));

    p_frames_r7: assert property (@(posedge clk) disable iff (rst)
        buf1_valid |-> (cnt_frames == $past(cnt_frames) + CNT_W'(1)));

    p_events_r8: assert property (@(posedge clk) disable iff (rst)
        buf1_valid |-> (ev_rx_done && ev_nis && !ev_ais));

    p_clear_r9: assert property (@(posedge clk)
        rst |=> (cnt_frames == '0 && cnt_bytes == '0 && !ev_rx_done));
endmodule

bind rx_desc_writeback rxwb_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .rx_en          (rx_en),
    .ring_base      (ring_base),
    .base_wr        (base_wr),
    .frm_start      (frm_start),
    .frm_len        (frm_len),
    .busy           (busy),
    .mem_rd_en      (mem_rd_en),
    .mem_wr_en      (mem_wr_en),
    .mem_wdata      (mem_wdata),
    .cur_ptr        (cur_ptr),
    .buf1_valid     (buf1_valid),
    .ev_rx_done     (ev_rx_done),
    .ev_nis         (ev_nis),
    .ev_buf_unavail (ev_buf_unavail),
    .ev_ais         (ev_ais),
    .cnt_frames     (cnt_frames),
    .cnt_bytes      (cnt_bytes)
);

// File: tb/rx_desc_writeback_bench.sv
module rx_desc_writeback_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic [31:0] ring_base = '0;
    logic        base_wr = 1'b0;
    logic        frm_start = 1'b0;
    logic [47:0] frm_dst = '0;
    logic [15:0] frm_len = '0;
    logic        busy, mem_rd_en, mem_wr_en, buf1_valid;
    logic [31:0] mem_addr, mem_wdata, cur_ptr, buf1_addr;
    logic [31:0] mem_rdata = '0;
    logic        ev_rx_done, ev_nis, ev_buf_unavail, ev_ais;
    logic [63:0] cnt_bytes, cnt_frames, cnt_mcast, cnt_bcast;

    always #2.5 clk = ~clk;

    rx_desc_writeback u_rx_desc_writeback (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base), .base_wr(base_wr),
        .frm_start(frm_start), .frm_dst(frm_dst), .frm_len(frm_len), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_ptr(cur_ptr),
        .buf1_addr(buf1_addr), .buf1_valid(buf1_valid), .ev_rx_done(ev_rx_done),
        .ev_nis(ev_nis), .ev_buf_unavail(ev_buf_unavail), .ev_ais(ev_ais),
        .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames), .cnt_mcast(cnt_mcast),
        .cnt_bcast(cnt_bcast)
    );

    // descriptor memory, one-cycle read latency
    logic [31:0] mem [64];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[7:2]];
        if (mem_wr_en) mem[mem_addr[7:2]] <= mem_wdata;
    end

    int cyc = 0;
    int rd_count = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef enum int {K_RUNT, K_NOBUF, K_ACCEPT} kind_t;
    typedef struct {
        kind_t       kind;
        int          due;
        logic [31:0] ptr;
        logic [31:0] bufa;
    } outcome_t;
    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
    } wr_t;

    outcome_t exp_q[$];
    wr_t      wr_q[$];

    // model state
    logic [31:0] m_ptr = '0;
    logic [63:0] m_bytes = '0, m_frames = '0, m_mcast = '0, m_bcast = '0;

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_en) rd_count++;
            if (ev_rx_done || ev_buf_unavail) begin
                if (exp_q.size() == 0) begin
                    check("R1/R11 unexpected event", 64'(ev_rx_done), 64'h0);
                end else begin
                    outcome_t o;
                    o = exp_q.pop_front();
                    check("R2/R3/R8 due cycle", 64'(cyc), 64'(o.due));
                    case (o.kind)
                        K_RUNT: begin
                            check("R2 rx_done+nis", 64'({ev_rx_done, ev_nis, ev_ais}), 64'b110);
                        end
                        K_NOBUF: begin
                            check("R3 unavail+ais", 64'({ev_buf_unavail, ev_ais, ev_rx_done}), 64'b110);
                            check("R3 pointer kept", 64'(cur_ptr), 64'(o.ptr));
                        end
                        default: begin
                            check("R8 events", 64'({ev_rx_done, ev_nis, buf1_valid, ev_ais}), 64'b1110);
                            check("R8 buffer address", 64'(buf1_addr), 64'(o.bufa));
                            check("R5 next pointer", 64'(cur_ptr), 64'(o.ptr));
                        end
                    endcase
                end
            end
            if (mem_wr_en) begin
                if (wr_q.size() == 0) begin
                    check("R3 unexpected write", 64'(mem_addr), 64'hFFFF_FFFF);
                end else begin
                    wr_t w;
                    w = wr_q.pop_front();
                    check("R4 write address", 64'(mem_addr), 64'(w.addr));
                    check("R4 status word", 64'(mem_wdata), 64'(w.data));
                end
            end
        end
    end

    task automatic set_desc(input logic [31:0] a, input bit own, input logic [15:0] sz,
                            input logic [31:0] bufa);
        mem[a[7:2]]     = {own, 31'h0};
        mem[a[7:2] + 1] = {16'h0, sz};
        mem[a[7:2] + 2] = bufa;
    endtask

    task automatic check_stats(input string tag);
        check({tag, " R7 bytes"}, cnt_bytes, m_bytes);
        check({tag, " R7 frames"}, cnt_frames, m_frames);
        check({tag, " R6 mcast"}, cnt_mcast, m_mcast);
        check({tag, " R6 bcast"}, cnt_bcast, m_bcast);
        check({tag, " R5 pointer"}, 64'(cur_ptr), 64'(m_ptr));
    endtask

    // driver: predicts outcome, pushes to scoreboard, pulses the start
    task automatic send(input logic [47:0] dst, input logic [15:0] len,
                        input bit en, input bit dbl);
        outcome_t o;
        @(negedge clk);
        rx_en = en;
        o.ptr = m_ptr;
        o.bufa = '0;
        if (en) begin
            if (len < 16'd12) begin
                o.kind = K_RUNT;
                o.due  = cyc + 1;
                exp_q.push_back(o);
            end else if (!mem[m_ptr[7:2]][31]) begin
                o.kind = K_NOBUF;
                o.due  = cyc + 3;
                exp_q.push_back(o);
            end else begin
                wr_t w;
                logic [15:0] tot;
                tot    = len + 16'd4;
                w.addr = m_ptr;
                w.data = {tot, 16'h0300};
                wr_q.push_back(w);
                o.kind = K_ACCEPT;
                o.due  = cyc + 5;
                o.bufa = mem[m_ptr[7:2] + 2];
                m_ptr  = mem[m_ptr[7:2] + 1][15] ? ring_base : m_ptr + 32'd32;
                o.ptr  = m_ptr;
                exp_q.push_back(o);
                m_bytes  = m_bytes + 64'(tot);
                m_frames = m_frames + 1;
                if (&dst) m_bcast = m_bcast + 1;
                else if (dst[0]) m_mcast = m_mcast + 1;
            end
        end
        frm_dst   = dst;
        frm_len   = len;
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = dbl;
        @(negedge clk);
        frm_start = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int rd_before;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 reset bytes", cnt_bytes, 64'h0);
        check("R9 reset frames", cnt_frames, 64'h0);
        check("R9 reset pointer", 64'(cur_ptr), 64'h0);
        check("R9 reset events", 64'({ev_rx_done, ev_nis, ev_buf_unavail, ev_ais, busy}), 64'h0);

        // R10: pointer load from base
        ring_base = 32'h40;
        base_wr   = 1'b1;
        @(negedge clk);
        base_wr = 1'b0;
        @(negedge clk);
        m_ptr = 32'h40;
        check("R10 base load", 64'(cur_ptr), 64'h40);

        set_desc(32'h40, 1'b1, 16'h0600, 32'h0000_1000);
        set_desc(32'h60, 1'b1, 16'h0600, 32'h0000_2000);
        set_desc(32'h80, 1'b1, 16'h8600, 32'h0000_3000);

        // R6 unicast, R4/R5 advance
        send(48'h0605_0403_0202, 16'd60, 1'b1, 1'b0);
        check_stats("unicast");

        // R1 refused
        rd_before = rd_count;
        send(48'h0605_0403_0202, 16'd64, 1'b0, 1'b0);
        check("R1 no reads", 64'(rd_count), 64'(rd_before));
        check_stats("refused R1");

        // R2 runt at 11 bytes
        rd_before = rd_count;
        send(48'hFFFF_FFFF_FFFF, 16'd11, 1'b1, 1'b0);
        check("R2 no reads", 64'(rd_count), 64'(rd_before));
        check_stats("runt R2");

        // 12 bytes accepted, multicast
        send(48'h0000_0000_0001, 16'd12, 1'b1, 1'b0);
        check_stats("mcast min");

        // broadcast on ring-end descriptor: wrap to base
        send(48'hFFFF_FFFF_FFFF, 16'd1500, 1'b1, 1'b0);
        check_stats("bcast wrap R5");

        // descriptor at base now written back: not owned
        send(48'h0000_0000_0002, 16'd100, 1'b1, 1'b0);
        check_stats("nobuf R3");

        // re-own, then a second start while busy must be ignored (R11)
        set_desc(32'h40, 1'b1, 16'h0600, 32'h0000_4000);
        send(48'hFEFF_FFFF_FFFF, 16'd200, 1'b1, 1'b1);
        check_stats("busy R11 near-bcast mcast R6");

        check("R11 scoreboard drained", 64'(exp_q.size() + wr_q.size()), 64'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule